// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block receives control writes over a three-line serial bus: a bus clock, a bus data line and a phase line. A faster system clock oversamples all three lines. Each bit is taken on a rising edge of the bus clock, and bits arrive least significant first. When the phase line is low, the byte being sent is an address byte. Its upper six bits must equal the device address, and its lower two bits choose which of two register sets later data is written to.

When the phase line is high, every complete byte is a data byte. Its top two bits pick one of four registers in the chosen set, and its low six bits are written into that register. The set chosen by an address byte stays in force for any number of data bytes, until the next address byte arrives. Writes only go into the block; nothing is read back.

Top module: `ctl3w_slave`

## Requirements
- R1: Bits are shifted in least significant bit first. The first bit taken after a phase change becomes bit 0 of the byte, and the eighth becomes bit 7.
- R2: An address byte is a byte received with the phase line low. When its bits 7:2 equal 000101, its bits 1:0 set the target: 00 targets the first set (`set_a_o`) and 10 targets the second set (`set_b_o`).
- R3: An address byte whose bits 7:2 differ from 000101 deselects the block. Data bytes that follow it change no register.
- R4: A matching address byte with bits 1:0 equal to 01 or 11 also deselects the block.
- R5: A selection stays in force for any number of data bytes, until the next complete address byte.
- R6: In a data byte (phase line high), bits 7:6 give the register index and bits 5:0 the value. Exactly that register of the selected set takes the value, and the field for index k is bits 6k+5:6k of the set output.
- R7: A register is written only after the eighth bit of a data byte. A byte cut short by a change of the phase line writes nothing.
- R8: Any change of the phase line clears the bit count. The next byte is then framed from its first bit.
- R9: Reset deselects the block and clears the bit count. It leaves the register contents as they were, and no register has a defined value before its first write.
- R10: A write to one set leaves every register of the other set unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; oversamples the bus lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Serial bus clock; a bit is taken on each rising edge |
| bus_dat_i | input | 1 | Serial bus data |
| bus_phase_i | input | 1 | Low for the address phase, high for the data phase |
| set_a_o | output | 24 | Four 6-bit registers of the first set; index k sits at bits 6k+5:6k |
| set_b_o | output | 24 | Four 6-bit registers of the second set; same layout |

## Verification
A rising bus-clock edge passes through two synchronizer flops and one edge-detect flop. On the eighth edge, a registered byte strobe follows one cycle later, and the register or selection update lands on the cycle after that. A write is therefore visible about five system cycles after the eighth bus-clock edge. The bench holds each bus level for several system cycles and, after every byte, waits ten system cycles before sampling on a falling system-clock edge, so each check falls well after the update is due. Phase-line changes are likewise followed by a settling wait before the next bit is sent.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int BYTE_W = 8;
  typedef enum logic [1:0] {SEL_NONE = 2'd0, SEL_A = 2'd1, SEL_B = 2'd2} sel_e;
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);
  for (genvar l = 0; l < LINES; l++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], async_i[l]};
    end
    assign sync_o[l] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/ctl3w_deser.sv
module ctl3w_deser
  import ctl3w_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              phase_i,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_data_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sclk_q, phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              rise, phase_chg, last_bit;

  assign rise      = sclk_i & ~sclk_q;
  assign phase_chg = phase_i ^ phase_q;
  assign last_bit  = (cnt_q == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      phase_q     <= 1'b0;
      cnt_q       <= '0;
      sh_q        <= '0;
      byte_vld_o  <= 1'b0;
      byte_o      <= '0;
      byte_data_o <= 1'b0;
    end else begin
      sclk_q     <= sclk_i;
      phase_q    <= phase_i;
      byte_vld_o <= 1'b0;
      if (phase_chg) begin
        cnt_q <= '0;  // partial byte dropped
      end else if (rise) begin
        sh_q  <= {sdat_i, sh_q[BYTE_W-1:1]};  // LSB first: shift right
        cnt_q <= last_bit ? '0 : cnt_q + 1'b1;
        if (last_bit) begin
          byte_vld_o  <= 1'b1;
          byte_o      <= {sdat_i, sh_q[BYTE_W-1:1]};
          byte_data_o <= phase_i;
        end
      end
    end
  end
endmodule

// File: rtl/ctl3w_select.sv
module ctl3w_select
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_data_i,
  output sel_e              sel_o
);
  sel_e sel_d;

  always_comb begin
    sel_d = sel_o;
    if (byte_vld_i && !byte_data_i) begin
      if (byte_i[BYTE_W-1:2] != DEV_ADDR) sel_d = SEL_NONE;
      else begin
        unique case (byte_i[1:0])
          2'b00:   sel_d = SEL_A;
          2'b10:   sel_d = SEL_B;
          default: sel_d = SEL_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_o <= SEL_NONE;
    else         sel_o <= sel_d;
  end
endmodule

// File: rtl/ctl3w_bank.sv
module ctl3w_bank #(
  parameter int IDX_W = 2,
  parameter int VAL_W = 6,
  localparam int NUM  = 1 << IDX_W
) (
  input  logic                 clk_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [VAL_W-1:0]     val_i,
  output logic [NUM*VAL_W-1:0] regs_o
);
  // no reset by intent: contents undefined until written
  for (genvar r = 0; r < NUM; r++) begin : g_reg
    logic [VAL_W-1:0] q;
    always_ff @(posedge clk_i) begin
      if (we_i && idx_i == IDX_W'(r)) q <= val_i;
    end
    assign regs_o[r*VAL_W +: VAL_W] = q;
  end
endmodule

// File: rtl/ctl3w_slave.sv
module ctl3w_slave
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR    = 6'b000101,
  parameter int         SYNC_STAGES = 2,
  parameter int         IDX_W       = 2,
  localparam int        VAL_W       = BYTE_W - IDX_W,
  localparam int        NUM_REGS    = 1 << IDX_W,
  localparam int        SET_W       = NUM_REGS * VAL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_clk_i,
  input  logic             bus_dat_i,
  input  logic             bus_phase_i,
  output logic [SET_W-1:0] set_a_o,
  output logic [SET_W-1:0] set_b_o
);
  logic [2:0]        lines_s;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_data;
  sel_e              sel;
  logic [1:0]        we;
  logic [SET_W-1:0]  bank_out [2];

  ctl3w_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni,
    .async_i({bus_phase_i, bus_dat_i, bus_clk_i}),
    .sync_o (lines_s)
  );

  ctl3w_deser u_deser (
    .clk_i, .rst_ni,
    .sclk_i     (lines_s[0]),
    .sdat_i     (lines_s[1]),
    .phase_i    (lines_s[2]),
    .byte_vld_o (byte_vld),
    .byte_o     (byte_q),
    .byte_data_o(byte_data)
  );

  ctl3w_select #(.DEV_ADDR(DEV_ADDR)) u_sel (
    .clk_i, .rst_ni,
    .byte_vld_i (byte_vld),
    .byte_i     (byte_q),
    .byte_data_i(byte_data),
    .sel_o      (sel)
  );

  for (genvar s = 0; s < 2; s++) begin : g_bank
    localparam sel_e MY_SEL = (s == 0) ? SEL_A : SEL_B;
    assign we[s] = byte_vld & byte_data & (sel == MY_SEL);
    ctl3w_bank #(.IDX_W(IDX_W), .VAL_W(VAL_W)) u_bank (
      .clk_i,
      .we_i  (we[s]),
      .idx_i (byte_q[BYTE_W-1 -: IDX_W]),
      .val_i (byte_q[VAL_W-1:0]),
      .regs_o(bank_out[s])
    );
  end

  assign set_a_o = bank_out[0];
  assign set_b_o = bank_out[1];
endmodule

// File: rtl/ctl3w_chk.sv
module ctl3w_chk
  import ctl3w_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR = 6'b000101,
  parameter int         SET_W    = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld,
  input logic [BYTE_W-1:0] byte_q,
  input logic              byte_data,
  input sel_e              sel,
  input logic [SET_W-1:0]  set_a_o,
  input logic [SET_W-1:0]  set_b_o
);
  p_no_write_without_byte_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_vld |=> ($stable(set_a_o) && $stable(set_b_o)));

  p_byte_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld |=> !byte_vld);

  p_mismatch_desel_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && !byte_data && byte_q[7:2] != DEV_ADDR) |=> (sel == SEL_NONE));

  p_unused_desel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && !byte_data && byte_q[0]) |=> (sel == SEL_NONE));

  p_idle_no_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && sel == SEL_NONE) |=> ($stable(set_a_o) && $stable(set_b_o)));

  p_a_spares_b_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_A) |=> $stable(set_b_o));

  p_b_spares_a_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel == SEL_B) |=> $stable(set_a_o));

  p_data_keeps_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vld && byte_data) |=> $stable(sel));
endmodule

bind ctl3w_slave ctl3w_chk #(.DEV_ADDR(DEV_ADDR), .SET_W(SET_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .byte_vld (byte_vld),
  .byte_q   (byte_q),
  .byte_data(byte_data),
  .sel      (sel),
  .set_a_o  (set_a_o),
  .set_b_o  (set_b_o)
);

// File: tb/tb_ctl3w_slave.sv
module tb_ctl3w_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, bdat = 1'b0, bphase = 1'b0;
  logic [23:0] set_a, set_b;

  int errors = 0, checks = 0;
  bit done = 1'b0;

  logic [5:0] exp_a [4], exp_b [4];
  bit         kn_a [4], kn_b [4];
  int         exp_sel = 0;  // 0 none, 1 A, 2 B

  always #5 clk = ~clk;

  ctl3w_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_clk_i(bclk), .bus_dat_i(bdat),
    .bus_phase_i(bphase), .set_a_o(set_a), .set_b_o(set_b)
  );

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    bdat = b; wait_clk(3);
    bclk = 1'b1; wait_clk(4);
    bclk = 1'b0; wait_clk(1);
  endtask

  task automatic set_phase(logic p);
    if (bphase !== p) begin bphase = p; wait_clk(6); end
  endtask

  task automatic send_byte(logic phase, logic [7:0] b);
    set_phase(phase);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
    wait_clk(10);
  endtask

  // model update from the requirements
  task automatic addr_byte(logic [7:0] b);
    send_byte(1'b0, b);
    if (b[7:2] != 6'b000101) exp_sel = 0;            // R3
    else if (b[1:0] == 2'b00) exp_sel = 1;           // R2
    else if (b[1:0] == 2'b10) exp_sel = 2;           // R2
    else exp_sel = 0;                                // R4
  endtask

  task automatic data_byte(logic [7:0] b);
    send_byte(1'b1, b);
    if (exp_sel == 1) begin exp_a[b[7:6]] = b[5:0]; kn_a[b[7:6]] = 1'b1; end
    if (exp_sel == 2) begin exp_b[b[7:6]] = b[5:0]; kn_b[b[7:6]] = 1'b1; end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < 4; k++) begin
      if (kn_a[k]) begin
        checks++;
        if (set_a[k*6 +: 6] !== exp_a[k]) begin
          errors++;
          $display("FAIL %s set_a[%0d] got=%h exp=%h", req, k, set_a[k*6 +: 6], exp_a[k]);
        end
      end
      if (kn_b[k]) begin
        checks++;
        if (set_b[k*6 +: 6] !== exp_b[k]) begin
          errors++;
          $display("FAIL %s set_b[%0d] got=%h exp=%h", req, k, set_b[k*6 +: 6], exp_b[k]);
        end
      end
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin kn_a[k] = 1'b0; kn_b[k] = 1'b0; end
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);

    // R1/R6: asymmetric values prove LSB-first order and field placement
    addr_byte(8'b000101_00);
    data_byte(8'b00_000001);
    data_byte(8'b01_100000);
    data_byte(8'b10_010110);
    data_byte(8'b11_101001);
    check_all("R1 R6");
    addr_byte(8'b000101_10);
    for (int k = 0; k < 4; k++) data_byte({2'(k), 6'(k * 13 + 7)});
    check_all("R2 R10");

    // R9: reset deselects, contents kept
    rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
    bphase = 1'b0; exp_sel = 0;
    data_byte(8'b10_111111);
    check_all("R9");

    // R5/R6/R10: one selection, sweep every value into every register
    addr_byte(8'b000101_00);
    for (int k = 0; k < 4; k++)
      for (int v = 0; v < 64; v += 3) begin
        data_byte({2'(k), 6'(v)});
        check_all("R5 R6 R10");
      end
    addr_byte(8'b000101_10);
    for (int k = 0; k < 4; k++)
      for (int v = 63; v >= 0; v -= 5) begin
        data_byte({2'(k), 6'(v)});
        check_all("R5 R6 R10");
      end

    // R2/R3/R4: every address with every selector code
    for (int a = 0; a < 64; a++)
      for (int s = 0; s < 4; s++) begin
        addr_byte({6'(a), 2'(s)});
        data_byte({2'(a + s), 6'(a ^ (s * 21))});
        check_all("R2 R3 R4");
      end

    // R7/R8: truncated data byte, then a clean one
    addr_byte(8'b000101_00);
    set_phase(1'b1);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    set_phase(1'b0);
    set_phase(1'b1);
    wait_clk(10);
    check_all("R7");
    data_byte(8'b01_010101);
    check_all("R8");
    // partial address bits then data phase: selection and framing intact
    set_phase(1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b0);
    data_byte(8'b11_000011);
    check_all("R5 R8");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule